// File: doc/BRIEF.md
# Multi-format PCM serial audio receiver

This block takes a three-wire serial audio stream (bit clock, word clock, serial data) and turns one chosen word of each frame into a parallel sample with a one-cycle valid strobe. It has no master clock input. Every register runs on the bit clock. One small register on the falling edge keeps the data bit for the falling-edge capture case.

The framing type is found from the shape of the word clock. A balanced word clock means stereo framing, and a static variant input then selects between I2S-style and left-justified framing. A one-bit-wide frame-sync pulse means 16-bit TDM framing with four slots. The variant input also sets which level of the word clock marks the left channel, and which bit-clock edge samples data in TDM. A two-bit channel-select input picks the delivered word or shuts the receiver down.

Top module: `pcm_serial_rx`

## Requirements
- R1: After reset, `sample_valid_o` is 0 and `sample_o` is all zeros.
- R2: At each rising edge of the word clock (as sampled on bit-clock rising edges), the framing is decided from the last complete high phase and the low phase that just ended. A high phase of exactly 1 bit period gives TDM. A high phase within one bit period of the low phase gives stereo. Any other shape keeps the previous framing. No sample is produced until a framing has been decided, which needs at least two word-clock rising edges after reset or shutdown.
- R3: Stereo with `variant_i`=0 (I2S style): the MSB is the bit sampled one bit clock after a word-clock edge, and the LSB is the bit sampled on the next edge. Word clock low marks the left word.
- R4: Stereo with `variant_i`=1 (left-justified): the MSB is the bit sampled on the word-clock edge itself. Word clock high marks the left word.
- R5: Stereo words of 16, 24 or 32 bits are delivered MSB-aligned at bit 31, with the unused low bits set to zero. Bits beyond the 32nd of a half-frame are dropped.
- R6: In TDM, bit position 0 is the bit sampled with the sync pulse high. Slot s covers positions 16s to 16s+15, MSB first. Slot 0 or slot 1 is delivered as {slot, 16 zeros}. Bits after position 63 are ignored.
- R7: In TDM, data is sampled on the bit-clock rising edge when `variant_i`=0, and on the falling edge before it when `variant_i`=1. Stereo framing always samples on the rising edge.
- R8: `chan_sel_i` = 01 selects the left word or slot 0, and 10 selects the right word or slot 1. Values 00 and 11 mean shutdown: no strobe is produced, and framing detection and word assembly restart.
- R9: `sample_valid_o` is high for exactly one cycle, in the cycle after the bit-clock rising edge that samples the word's last bit. `sample_o` holds its value until the next strobe.
- R10: The decided framing changes only at a word-clock rising edge, or through shutdown or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Serial bit clock, the only clock |
| rst | input | 1 | Synchronous active-high reset |
| ws_i | input | 1 | Word clock or frame-sync pulse |
| sd_i | input | 1 | Serial data, MSB first |
| variant_i | input | 1 | 0: I2S style, left on low, TDM rising capture; 1: left-justified, left on high, TDM falling capture |
| chan_sel_i | input | 2 | 01 left / slot 0, 10 right / slot 1, 00 or 11 shutdown |
| sample_o | output | 32 | Received word, MSB-aligned |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample |

## Verification
Balanced stereo word clocks at 32, 24 and 16 bits per half are sent with both variant settings and both channels. These runs separate the one-bit I2S delay from left-justified alignment, show the polarity swap between variants, and show the zero fill of short words. One-bit sync pulses in 64-bit frames check slot placement and the choice of sampling edge. The bench drives the opposite bit value on the other clock edge, so any wrong edge choice shows up. A stereo stream that turns into TDM without a shutdown, followed by a word clock that fits neither shape, checks that the framing only changes at a rising edge and keeps its last value when the shape is not recognised.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;
  typedef enum logic [1:0] {
    FMT_NONE   = 2'd0,
    FMT_STEREO = 2'd1,
    FMT_TDM    = 2'd2
  } fmt_e;
endpackage

// File: rtl/pcmrx_frame_detect.sv
module pcmrx_frame_detect
  import pcmrx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ws_i,
  output logic ws_edge_o,
  output logic ws_rise_o,
  output fmt_e fmt_eff_o,
  output fmt_e fmt_q_o
);
  localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

  logic             ws_prev;
  logic [CNT_W-1:0] run;
  logic [CNT_W-1:0] hi_len;
  logic [CNT_W-1:0] diff;
  logic             seen;
  logic             have_hi;
  logic             rise;
  logic             fall;
  fmt_e             fmt_q;
  fmt_e             decide;

  assign rise = ws_i & ~ws_prev;
  assign fall = ~ws_i & ws_prev;

  // run holds the low-phase length at a rising edge
  always_comb begin
    diff   = (hi_len >= run) ? (hi_len - run) : (run - hi_len);
    decide = fmt_q;
    if (have_hi) begin
      if (hi_len == CNT_W'(1))
        decide = FMT_TDM;
      else if (diff <= CNT_W'(1))
        decide = FMT_STEREO;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_prev <= 1'b0;
      run     <= '0;
      hi_len  <= '0;
      seen    <= 1'b0;
      have_hi <= 1'b0;
      fmt_q   <= FMT_NONE;
    end else begin
      ws_prev <= ws_i;
      if (rise || fall)
        run <= CNT_W'(1);
      else if (run != RUN_MAX)
        run <= run + CNT_W'(1);
      if (rise || fall)
        seen <= 1'b1;
      if (fall && seen) begin
        hi_len  <= run;
        have_hi <= 1'b1;
      end
      if (rise)
        fmt_q <= decide;
    end
  end

  assign ws_edge_o = rise | fall;
  assign ws_rise_o = rise;
  assign fmt_eff_o = rise ? decide : fmt_q;
  assign fmt_q_o   = fmt_q;
endmodule

// File: rtl/pcmrx_stereo_asm.sv
module pcmrx_stereo_asm #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              edge_i,
  input  logic              ws_i,
  input  logic              bit_i,
  input  logic              lj_i,
  input  logic              want_left_i,
  input  logic              want_right_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  localparam int K_W = $clog2(WORD_W) + 1;
  localparam logic [WORD_W-1:0] TOP_BIT = {1'b1, {(WORD_W-1){1'b0}}};

  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] mask;
  logic [K_W-1:0]    k;
  logic              word_ok;
  logic              word_left;

  // one-hot position of the next bit, empty once the word is full
  assign mask = (k < K_W'(WORD_W)) ? (TOP_BIT >> k) : '0;

  always_comb begin
    data_o = acc;
    if (!lj_i && bit_i)
      data_o = acc | mask;
  end

  assign valid_o = en && edge_i && word_ok &&
                   (word_left ? want_left_i : want_right_i);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      acc       <= '0;
      k         <= '0;
      word_ok   <= 1'b0;
      word_left <= 1'b0;
    end else if (edge_i) begin
      word_ok   <= 1'b1;
      word_left <= (ws_i == lj_i);
      if (lj_i) begin
        acc <= bit_i ? TOP_BIT : '0;
        k   <= K_W'(1);
      end else begin
        acc <= '0;
        k   <= '0;
      end
    end else if (k < K_W'(WORD_W)) begin
      if (bit_i)
        acc <= acc | mask;
      k <= k + K_W'(1);
    end
  end
endmodule

// File: rtl/pcmrx_tdm_asm.sv
module pcmrx_tdm_asm #(
  parameter int SLOT_W = 16,
  parameter int SLOTS  = 4,
  parameter int OUT_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rise_i,
  input  logic             bit_i,
  input  logic             slot_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o
);
  localparam int FRAME_BITS = SLOT_W * SLOTS;
  localparam int POS_W      = $clog2(FRAME_BITS + 1);

  logic [POS_W-1:0]  fpos;
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  first;
  logic [POS_W-1:0]  last;
  logic [SLOT_W-2:0] sh;
  logic              in_slot;

  assign pos     = rise_i ? '0 : fpos;
  assign first   = slot_i ? POS_W'(SLOT_W) : '0;
  assign last    = first + POS_W'(SLOT_W - 1);
  assign in_slot = (pos >= first) && (pos <= last);
  assign valid_o = en && (pos == last);
  assign data_o  = {sh, bit_i, {(OUT_W-SLOT_W){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      fpos <= POS_W'(FRAME_BITS);
      sh   <= '0;
    end else begin
      if (pos < POS_W'(FRAME_BITS))
        fpos <= pos + POS_W'(1);
      if (in_slot)
        sh <= {sh[SLOT_W-3:0], bit_i};
    end
  end
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcmrx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SLOT_W = 16,
  parameter int SLOTS  = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk_bit,
  input  logic              rst,
  input  logic              ws_i,
  input  logic              sd_i,
  input  logic              variant_i,
  input  logic [1:0]        chan_sel_i,
  output logic [WORD_W-1:0] sample_o,
  output logic              sample_valid_o
);
  logic              shutdown;
  logic              core_rst;
  logic              ws_edge;
  logic              ws_rise;
  fmt_e              fmt_eff;
  fmt_e              fmt_q;
  logic              sd_fall;
  logic              bit_sel;
  logic              st_v;
  logic              td_v;
  logic [WORD_W-1:0] st_d;
  logic [WORD_W-1:0] td_d;

  assign shutdown = (chan_sel_i == 2'b00) || (chan_sel_i == 2'b11);
  assign core_rst = rst || shutdown;

  pcmrx_frame_detect #(.CNT_W(CNT_W)) i_detect (
    .clk       (clk_bit),
    .rst       (core_rst),
    .ws_i      (ws_i),
    .ws_edge_o (ws_edge),
    .ws_rise_o (ws_rise),
    .fmt_eff_o (fmt_eff),
    .fmt_q_o   (fmt_q)
  );

  // data held from the falling edge for falling-edge TDM capture
  always_ff @(negedge clk_bit) begin
    if (rst) sd_fall <= 1'b0;
    else     sd_fall <= sd_i;
  end

  assign bit_sel = (fmt_eff == FMT_TDM && variant_i) ? sd_fall : sd_i;

  pcmrx_stereo_asm #(.WORD_W(WORD_W)) i_stereo (
    .clk          (clk_bit),
    .rst          (core_rst),
    .en           (fmt_eff == FMT_STEREO),
    .edge_i       (ws_edge),
    .ws_i         (ws_i),
    .bit_i        (bit_sel),
    .lj_i         (variant_i),
    .want_left_i  (chan_sel_i == 2'b01),
    .want_right_i (chan_sel_i == 2'b10),
    .valid_o      (st_v),
    .data_o       (st_d)
  );

  pcmrx_tdm_asm #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .OUT_W(WORD_W)) i_tdm (
    .clk     (clk_bit),
    .rst     (core_rst),
    .en      (fmt_eff == FMT_TDM),
    .rise_i  (ws_rise),
    .bit_i   (bit_sel),
    .slot_i  (chan_sel_i == 2'b10),
    .valid_o (td_v),
    .data_o  (td_d)
  );

  always_ff @(posedge clk_bit) begin
    if (rst) begin
      sample_o       <= '0;
      sample_valid_o <= 1'b0;
    end else if (shutdown) begin
      sample_valid_o <= 1'b0;
    end else begin
      sample_valid_o <= st_v || td_v;
      if (st_v)      sample_o <= st_d;
      else if (td_v) sample_o <= td_d;
    end
  end
endmodule

// File: rtl/pcmrx_checker.sv
module pcmrx_checker
  import pcmrx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SLOT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        chan_sel,
  input logic              valid,
  input logic [WORD_W-1:0] sample,
  input fmt_e              fmt_q,
  input fmt_e              fmt_eff,
  input logic              ws_rise
);
  logic off;
  assign off = (chan_sel == 2'b00) || (chan_sel == 2'b11);

  AST_SHUTDOWN_SILENT: assert property (@(posedge clk) disable iff (rst)
    off |=> !valid); // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R9
  AST_FMT_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    !$stable(fmt_q) |-> ($past(ws_rise) || $past(off))); // R10
  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    valid |-> ($past(fmt_eff) != FMT_NONE)); // R2
  AST_TDM_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (valid && fmt_q == FMT_TDM) |-> (sample[WORD_W-SLOT_W-1:0] == '0)); // R6
endmodule

bind pcm_serial_rx pcmrx_checker #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) i_chk (
  .clk      (clk_bit),
  .rst      (rst),
  .chan_sel (chan_sel_i),
  .valid    (sample_valid_o),
  .sample   (sample_o),
  .fmt_q    (fmt_q),
  .fmt_eff  (fmt_eff),
  .ws_rise  (ws_rise)
);

// File: tb/test_pcm_serial_rx.sv
module test_pcm_serial_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ws = 1'b0;
  logic        sd = 1'b0;
  logic        variant = 1'b0;
  logic [1:0]  sel = 2'b01;
  logic [31:0] sample;
  logic        valid;

  pcm_serial_rx i_pcm_serial_rx (
    .clk_bit        (clk),
    .rst            (rst),
    .ws_i           (ws),
    .sd_i           (sd),
    .variant_i      (variant),
    .chan_sel_i     (sel),
    .sample_o       (sample),
    .sample_valid_o (valid)
  );

  always #2 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string req = "R1";

  bit       want_rst = 1;
  bit [1:0] want_sel = 2'b01;
  bit       want_var = 0;

  // reference model state
  int m_prev_ws, m_run, m_seen, m_have_hi, m_hi_len, m_mode, m_eff;
  bit q_st[$];
  bit q_td[$];
  int st_ok, st_left, td_on;
  bit          exp_v = 0;
  logic [31:0] exp_d = '0;

  function automatic logic [31:0] pack(input bit q[$], input int from, input int n);
    logic [31:0] val = '0;
    for (int i = 0; i < n && from + i < q.size(); i++) val[31-i] = q[from+i];
    return val;
  endfunction

  task automatic model_clear();
    m_prev_ws = 0; m_run = 0; m_seen = 0; m_have_hi = 0; m_hi_len = 0;
    m_mode = 0; m_eff = 0; st_ok = 0; st_left = 0; td_on = 0;
    q_st.delete(); q_td.delete();
  endtask

  task automatic model_step(input bit w, input bit d);
    bit rise, fall, edg;
    int dd, slot;
    exp_v = 0;
    if (want_rst || want_sel == 2'b00 || want_sel == 2'b11) begin
      model_clear();
      if (want_rst) exp_d = '0;
      return;
    end
    rise = w && !m_prev_ws;
    fall = !w && m_prev_ws;
    edg  = rise || fall;
    m_eff = m_mode;
    if (rise && m_have_hi) begin
      dd = m_hi_len - m_run;
      if (dd < 0) dd = -dd;
      if (m_hi_len == 1) m_eff = 2;
      else if (dd <= 1) m_eff = 1;
    end
    if (m_eff == 1) begin
      if (edg) begin
        if (!want_var) q_st.push_back(d);
        if (st_ok && ((st_left && want_sel == 2'b01) || (!st_left && want_sel == 2'b10))) begin
          exp_v = 1;
          exp_d = pack(q_st, 0, 32);
        end
        q_st.delete();
        if (want_var) q_st.push_back(d);
        st_ok = 1;
        st_left = (w == want_var);
      end else q_st.push_back(d);
    end else begin
      q_st.delete();
      st_ok = 0;
    end
    if (m_eff == 2) begin
      if (rise) begin q_td.delete(); td_on = 1; end
      if (td_on && q_td.size() < 64) begin
        q_td.push_back(d);
        slot = (want_sel == 2'b10) ? 1 : 0;
        if (q_td.size() == 16 * slot + 16) begin
          exp_v = 1;
          exp_d = pack(q_td, 16 * slot, 16);
        end
      end
    end else begin
      q_td.delete();
      td_on = 0;
    end
    if (fall && m_seen) begin m_hi_len = m_run; m_have_hi = 1; end
    if (edg) begin m_seen = 1; m_run = 1; end
    else if (m_run < 255) m_run++;
    if (rise) m_mode = m_eff;
    m_prev_ws = w;
  endtask

  task automatic check();
    total++;
    if (valid !== exp_v || sample !== exp_d) begin
      bad++;
      $display("FAIL %s: valid=%0b sample=%h expected valid=%0b sample=%h at %0t",
               req, valid, sample, exp_v, exp_d, $time);
    end
  endtask

  // one bit period: check the previous prediction, then predict and drive
  task automatic send(input bit w, input bit d);
    @(posedge clk);
    #1;
    check();
    model_step(w, d);
    rst <= want_rst;
    sel <= want_sel;
    variant <= want_var;
    ws <= w;
    if (m_eff == 2 && want_var) begin
      sd <= d;
      #2 sd <= ~d;
    end else begin
      sd <= ~d;
      #2 sd <= d;
    end
  endtask

  task automatic stereo_frames(input int half, input int n);
    bit lft = want_var;
    for (int f = 0; f < n; f++) begin
      for (int i = 0; i < half; i++) send(lft, 1'($urandom));
      for (int i = 0; i < half; i++) send(!lft, 1'($urandom));
    end
  endtask

  task automatic tdm_frames(input int hi, input int len, input int n);
    for (int f = 0; f < n; f++) begin
      for (int i = 0; i < hi; i++) send(1'b1, 1'($urandom));
      for (int i = hi; i < len; i++) send(1'b0, 1'($urandom));
    end
  endtask

  task automatic go_off(input int n);
    req = "R8";
    want_sel = 2'b00;
    for (int i = 0; i < n; i++) send(1'b0, 1'($urandom));
  endtask

  initial begin
    model_clear();
    req = "R1";
    want_rst = 1;
    for (int i = 0; i < 4; i++) send(1'b0, 1'b0);
    want_rst = 0;
    for (int i = 0; i < 3; i++) send(1'b0, 1'b0);

    req = "R3/R5/R9 i2s 32 left";
    want_var = 0; want_sel = 2'b01;
    stereo_frames(32, 5);
    go_off(5);
    req = "R3/R5 i2s 32 right";
    want_sel = 2'b10;
    stereo_frames(32, 5);
    go_off(5);
    req = "R4/R5 lj 24 left";
    want_var = 1; want_sel = 2'b01;
    stereo_frames(24, 5);
    go_off(5);
    req = "R4 lj 24 right";
    want_sel = 2'b10;
    stereo_frames(24, 4);
    go_off(5);
    req = "R5/R3 i2s 16 right";
    want_var = 0; want_sel = 2'b10;
    stereo_frames(16, 5);
    go_off(3);
    want_sel = 2'b11;
    for (int i = 0; i < 40; i++) send(i[2], 1'($urandom));

    req = "R6/R7 tdm rising slot0";
    want_var = 0; want_sel = 2'b01;
    tdm_frames(1, 64, 6);
    go_off(5);
    req = "R6/R7 tdm falling slot1";
    want_var = 1; want_sel = 2'b10;
    tdm_frames(1, 64, 6);
    go_off(5);
    req = "R7 tdm falling slot0";
    want_sel = 2'b01;
    tdm_frames(1, 64, 4);
    go_off(5);

    req = "R10/R2 stereo then tdm";
    want_var = 0; want_sel = 2'b01;
    stereo_frames(32, 4);
    tdm_frames(1, 64, 5);
    req = "R2/R10 unrecognised shape";
    tdm_frames(5, 25, 4);
    req = "R2 tdm again";
    tdm_frames(1, 64, 3);
    send(1'b0, 1'b0);
    send(1'b0, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule